// File: doc/BRIEF.md
# Shared Fault Line and Overvoltage Flag Controller

This block sits between a power sequencer's rail monitors and a fault line that several sequencer controllers share. The line is open-drain and wired-AND: it idles high through an external pull-up, and any controller may pull it low. When a monitored rail loses its good status while the controller is enabled and not shutting down, the block pulls the shared line low. It holds that pull for a minimum number of clock cycles so that every other controller on the line sees it.

In the other direction, the block synchronises the sampled line and filters it. A low level is reported as an external fault only after it has lasted the same minimum width. While the block is driving the line, and for a short tail afterwards, it ignores the line, so a fault raised locally is not reported a second time as an external one. A separate path combines the per-rail overvoltage flags into one active-low overvoltage output. That output asserts as soon as any flag is set. It is released only after all flags have stayed clear for a fixed number of cycles.

Top module: `flt_ovp_ctl`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `fault_pull_o` is 0, `ext_fault_o` is 0 and `ov_n_o` is 1 (released).
- R2: When any bit of `rail_good` goes from 1 to 0 between two consecutive clock edges while `enable_ok` and `shdn_n` are both 1, `fault_pull_o` is 1 after the next clock edge.
- R3: A 1-to-0 change of a `rail_good` bit while `enable_ok` is 0 or `shdn_n` is 0 leaves `fault_pull_o` at 0.
- R4: `fault_pull_o` stays 1 for exactly PULSE_CYC cycles after the most recent qualifying drop. A new drop during the pulse restarts the full width.
- R5: A low on `fault_line_i` lasting fewer than PULSE_CYC clock cycles never raises `ext_fault_o`.
- R6: A low on `fault_line_i` lasting PULSE_CYC cycles or more raises `ext_fault_o` PULSE_CYC+2 cycles after the line went low. This latency is two synchroniser stages plus the filter. The output stays 1 while the line stays low and falls three cycles after the line returns high.
- R7: A low on the line caused only by the block's own `fault_pull_o` never raises `ext_fault_o`.
- R8: If any bit of `rail_ov` is 1, `ov_n_o` is 0 after the next clock edge.
- R9: `ov_n_o` returns to 1 only after `rail_ov` has been all zeros for OV_REL_CYC consecutive clock edges. A flag set during that wait restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rail_good | input | N_RAILS | Per-rail undervoltage comparator result, 1 = above threshold |
| rail_ov | input | N_RAILS | Per-rail overvoltage comparator result, 1 = over threshold |
| enable_ok | input | 1 | Controller enable condition is met |
| shdn_n | input | 1 | Shutdown request, active low |
| fault_line_i | input | 1 | Sampled level of the shared fault line (asynchronous) |
| fault_pull_o | output | 1 | 1 = pull the shared fault line low |
| ext_fault_o | output | 1 | Qualified fault raised by another controller on the line |
| ov_n_o | output | 1 | Overvoltage indication, active low |

## Verification
The assertions assume that `rail_good`, `rail_ov`, `enable_ok` and `shdn_n` are already synchronous to `clk`. They also assume that `fault_line_i` is the wired-AND of this block's own pull and any external driver, so that a line low inside the self-mask window comes from this block. The bench builds the line exactly that way and changes every input only on the falling clock edge. External lows are held for chosen whole-cycle lengths just below, at, and above the minimum width. During the random phase only the block's own pull lowers the line.

// File: rtl/flt_pkg.sv
package flt_pkg;

    // Default sizing: 1.9 us minimum pulse at a 10 MHz control clock.
    localparam int unsigned RAILS_DEF   = 4;
    localparam int unsigned PULSE_DEF   = 19;
    localparam int unsigned OVREL_DEF   = 8;
    localparam int unsigned SYNC_STAGES = 2;

    // Bits needed to hold a count from 0 up to and including v.
    function automatic int unsigned cnt_bits(input int unsigned v);
        return (v < 1) ? 1 : $clog2(v + 1);
    endfunction

    // Overvoltage output state.
    typedef enum logic [1:0] {
        OVS_IDLE   = 2'd0,
        OVS_ACTIVE = 2'd1,
        OVS_DRAIN  = 2'd2
    } ov_state_e;

    // Fault filter datapath: synchroniser and self-mask history.
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [SYNC_STAGES-1:0] own;
    } flt_hist_t;

endpackage

// File: rtl/flt_fault_drive.sv
module flt_fault_drive
    import flt_pkg::*;
#(
    parameter int unsigned N_RAILS   = RAILS_DEF,
    parameter int unsigned PULSE_CYC = PULSE_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_RAILS-1:0] rail_good,
    input  logic               enable_ok,
    input  logic               shdn_n,
    output logic               pull_o
);
    localparam int unsigned CW = cnt_bits(PULSE_CYC);

    logic [N_RAILS-1:0] good_q;
    logic [N_RAILS-1:0] rail_drop;
    logic [CW-1:0]      width_cnt;
    logic               armed;
    logic               trigger;

    // One falling-edge detector per rail.
    for (genvar g = 0; g < N_RAILS; g++) begin : g_drop
        assign rail_drop[g] = good_q[g] & ~rail_good[g];
    end

    assign armed   = enable_ok & shdn_n;
    assign trigger = armed & (|rail_drop);

    always_ff @(posedge clk) begin
        if (rst) begin
            good_q    <= '0;
            width_cnt <= '0;
        end else begin
            good_q <= rail_good;
            if (trigger) begin
                width_cnt <= CW'(PULSE_CYC);
            end else if (width_cnt != '0) begin
                width_cnt <= width_cnt - 1'b1;
            end
        end
    end

    assign pull_o = (width_cnt != '0);

endmodule

// File: rtl/flt_fault_filter.sv
module flt_fault_filter
    import flt_pkg::*;
#(
    parameter int unsigned PULSE_CYC = PULSE_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    input  logic own_pull,
    output logic ext_o
);
    localparam int unsigned CW = cnt_bits(PULSE_CYC);

    flt_hist_t     hist;
    logic [CW-1:0] low_cnt;
    logic          line_s;
    logic          masked;

    assign line_s = hist.sync[SYNC_STAGES-1];
    // Own pull plus a tail as long as the synchroniser delay.
    assign masked = own_pull | (|hist.own);

    always_ff @(posedge clk) begin
        if (rst) begin
            hist.sync <= '1;
            hist.own  <= '0;
            low_cnt   <= '0;
        end else begin
            hist.sync <= {hist.sync[SYNC_STAGES-2:0], line_i};
            hist.own  <= {hist.own[SYNC_STAGES-2:0], own_pull};
            if (masked || line_s) begin
                low_cnt <= '0;
            end else if (low_cnt != CW'(PULSE_CYC)) begin
                low_cnt <= low_cnt + 1'b1;
            end
        end
    end

    assign ext_o = (low_cnt == CW'(PULSE_CYC));

endmodule

// File: rtl/flt_ov_flag.sv
module flt_ov_flag
    import flt_pkg::*;
#(
    parameter int unsigned N_RAILS    = RAILS_DEF,
    parameter int unsigned OV_REL_CYC = OVREL_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_RAILS-1:0] rail_ov,
    output logic               ov_n_o
);
    localparam int unsigned RW = cnt_bits(OV_REL_CYC);

    ov_state_e     state;
    logic [RW-1:0] clr_cnt;
    logic          any_ov;

    assign any_ov = |rail_ov;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= OVS_IDLE;
            clr_cnt <= '0;
        end else if (any_ov) begin
            state   <= OVS_ACTIVE;
            clr_cnt <= '0;
        end else begin
            unique case (state)
                OVS_ACTIVE: begin
                    if (OV_REL_CYC <= 1) begin
                        state <= OVS_IDLE;
                    end else begin
                        state   <= OVS_DRAIN;
                        clr_cnt <= RW'(1);
                    end
                end
                OVS_DRAIN: begin
                    if (clr_cnt >= RW'(OV_REL_CYC - 1)) begin
                        state <= OVS_IDLE;
                    end else begin
                        clr_cnt <= clr_cnt + 1'b1;
                    end
                end
                default: state <= OVS_IDLE;
            endcase
        end
    end

    assign ov_n_o = (state == OVS_IDLE);

endmodule

// File: rtl/flt_ovp_ctl.sv
module flt_ovp_ctl
    import flt_pkg::*;
#(
    parameter int unsigned N_RAILS    = RAILS_DEF,
    parameter int unsigned PULSE_CYC  = PULSE_DEF,
    parameter int unsigned OV_REL_CYC = OVREL_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_RAILS-1:0] rail_good,
    input  logic [N_RAILS-1:0] rail_ov,
    input  logic               enable_ok,
    input  logic               shdn_n,
    input  logic               fault_line_i,
    output logic               fault_pull_o,
    output logic               ext_fault_o,
    output logic               ov_n_o
);
    logic pull_int;

    flt_fault_drive #(
        .N_RAILS   (N_RAILS),
        .PULSE_CYC (PULSE_CYC)
    ) u_drive (
        .clk       (clk),
        .rst       (rst),
        .rail_good (rail_good),
        .enable_ok (enable_ok),
        .shdn_n    (shdn_n),
        .pull_o    (pull_int)
    );

    flt_fault_filter #(
        .PULSE_CYC (PULSE_CYC)
    ) u_filter (
        .clk      (clk),
        .rst      (rst),
        .line_i   (fault_line_i),
        .own_pull (pull_int),
        .ext_o    (ext_fault_o)
    );

    flt_ov_flag #(
        .N_RAILS    (N_RAILS),
        .OV_REL_CYC (OV_REL_CYC)
    ) u_ov (
        .clk     (clk),
        .rst     (rst),
        .rail_ov (rail_ov),
        .ov_n_o  (ov_n_o)
    );

    assign fault_pull_o = pull_int;

endmodule

// File: rtl/flt_ovp_chk.sv
module flt_ovp_chk
    import flt_pkg::*;
#(
    parameter int unsigned N_RAILS    = RAILS_DEF,
    parameter int unsigned PULSE_CYC  = PULSE_DEF,
    parameter int unsigned OV_REL_CYC = OVREL_DEF
) (
    input logic               clk,
    input logic               rst,
    input logic [N_RAILS-1:0] rail_good,
    input logic [N_RAILS-1:0] rail_ov,
    input logic               enable_ok,
    input logic               shdn_n,
    input logic               fault_line_i,
    input logic               fault_pull_o,
    input logic               ext_fault_o,
    input logic               ov_n_o
);
    localparam int unsigned CW = cnt_bits(PULSE_CYC);

    logic [N_RAILS-1:0] good_seen;
    logic [CW-1:0]      pull_run;
    logic               qual_drop;

    assign qual_drop = enable_ok & shdn_n & (|(good_seen & ~rail_good));

    always_ff @(posedge clk) begin
        if (rst) begin
            good_seen <= '0;
            pull_run  <= '0;
        end else begin
            good_seen <= rail_good;
            if (!fault_pull_o) begin
                pull_run <= '0;
            end else if (pull_run != CW'(PULSE_CYC)) begin
                pull_run <= pull_run + 1'b1;
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!fault_pull_o && !ext_fault_o && ov_n_o)); // R1

    AST_PULL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_pull_o) |-> $past(qual_drop)); // R2 R3

    AST_PULL_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_pull_o) |-> (pull_run == CW'(PULSE_CYC))); // R4

    AST_EXT_NEEDS_LOW: assert property (@(posedge clk) disable iff (rst)
        ext_fault_o |-> !$past(fault_line_i, SYNC_STAGES + 1)); // R6

    AST_OWN_MASKED: assert property (@(posedge clk) disable iff (rst)
        (fault_pull_o && $past(fault_pull_o)) |-> !ext_fault_o); // R7

    AST_OV_SET: assert property (@(posedge clk) disable iff (rst)
        (|rail_ov) |=> !ov_n_o); // R8

    AST_OV_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $rose(ov_n_o) |-> ($past(rail_ov) == '0)); // R9

endmodule

bind flt_ovp_ctl flt_ovp_chk #(
    .N_RAILS    (N_RAILS),
    .PULSE_CYC  (PULSE_CYC),
    .OV_REL_CYC (OV_REL_CYC)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rail_good    (rail_good),
    .rail_ov      (rail_ov),
    .enable_ok    (enable_ok),
    .shdn_n       (shdn_n),
    .fault_line_i (fault_line_i),
    .fault_pull_o (fault_pull_o),
    .ext_fault_o  (ext_fault_o),
    .ov_n_o       (ov_n_o)
);

// File: tb/flt_ovp_ctl_test.sv
module flt_ovp_ctl_test;
    import flt_pkg::*;

    localparam int  N   = RAILS_DEF;
    localparam int  P   = PULSE_DEF;
    localparam int  REL = OVREL_DEF;
    localparam time CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] good = '1;
    logic [N-1:0] ov = '0;
    logic         en = 1'b1;
    logic         shdn_n = 1'b1;
    logic         ext_drv_n = 1'b1;
    logic         fault_line;
    logic         pull, ext, ov_n;

    int errors = 0;
    int checks = 0;
    bit auto_on = 1'b0;

    // Wired-AND shared line: own pull or another controller.
    assign fault_line = ~pull & ext_drv_n;

    flt_ovp_ctl uut (
        .clk          (clk),
        .rst          (rst),
        .rail_good    (good),
        .rail_ov      (ov),
        .enable_ok    (en),
        .shdn_n       (shdn_n),
        .fault_line_i (fault_line),
        .fault_pull_o (pull),
        .ext_fault_o  (ext),
        .ov_n_o       (ov_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Expected-value functions taken from R2..R4 and R8..R9.
    function automatic int pull_left_next(int left, logic [N-1:0] prev,
                                          logic [N-1:0] cur, logic e, logic s);
        if (e && s && (|(prev & ~cur))) return P;
        return (left > 0) ? left - 1 : 0;
    endfunction

    function automatic int clear_run_next(logic [N-1:0] flags, int run);
        if (|flags) return 0;
        return (run < REL) ? run + 1 : run;
    endfunction

    logic [N-1:0] m_prev;
    int           m_left;
    int           m_run;

    always @(posedge clk) begin
        if (rst) begin
            m_prev <= '0;
            m_left <= 0;
            m_run  <= REL;
        end else begin
            m_left <= pull_left_next(m_left, m_prev, good, en, shdn_n);
            m_prev <= good;
            m_run  <= clear_run_next(ov, m_run);
        end
    end

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (auto_on && !rst) begin
            chk("R4 pull model", pull, m_left > 0);
            chk("R9 ov model", ov_n, m_run >= REL);
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        tick(3);
        chk("R1 pull", pull, 1'b0);
        chk("R1 ext", ext, 1'b0);
        chk("R1 ov_n", ov_n, 1'b1);
        rst = 1'b0;
        auto_on = 1'b1;
        tick(3);

        // R2, R4: single qualified drop, own pulse masked (R7)
        good[2] = 1'b0;
        for (int i = 1; i <= P + 6; i++) begin
            tick(1);
            if (i == 1) begin
                chk("R2", pull, 1'b1);
                good[2] = 1'b1;
            end
            chk("R4", pull, i <= P);
            chk("R7", ext, 1'b0);
        end

        // R3: drop with enable low, then with shutdown asserted
        en = 1'b0;
        tick(2);
        good[1] = 1'b0;
        for (int i = 0; i < 4; i++) begin
            tick(1);
            chk("R3 enable low", pull, 1'b0);
        end
        good[1] = 1'b1;
        tick(2);
        en = 1'b1;
        shdn_n = 1'b0;
        tick(2);
        good[0] = 1'b0;
        for (int i = 0; i < 4; i++) begin
            tick(1);
            chk("R3 shutdown", pull, 1'b0);
        end
        good[0] = 1'b1;
        tick(2);
        shdn_n = 1'b1;
        tick(2);

        // R4: retrigger restarts the width
        good[0] = 1'b0;
        tick(2);
        good[0] = 1'b1;
        tick(3);
        good[3] = 1'b0;
        for (int i = 1; i <= P + 3; i++) begin
            tick(1);
            if (i == 1) good[3] = 1'b1;
            chk("R4 retrigger", pull, i <= P);
            chk("R7", ext, 1'b0);
        end
        tick(4);

        // R5: external low one cycle short of the minimum
        ext_drv_n = 1'b0;
        tick(P - 1);
        ext_drv_n = 1'b1;
        for (int i = 0; i < P + 6; i++) begin
            tick(1);
            chk("R5", ext, 1'b0);
        end

        // R6: long external low
        ext_drv_n = 1'b0;
        tick(P + 1);
        chk("R6 before latency", ext, 1'b0);
        tick(1);
        chk("R6 at latency", ext, 1'b1);
        tick(8);
        chk("R6 held", ext, 1'b1);
        ext_drv_n = 1'b1;
        tick(2);
        chk("R6 release pending", ext, 1'b1);
        tick(1);
        chk("R6 released", ext, 1'b0);
        tick(4);

        // R6: external low of exactly the minimum width
        ext_drv_n = 1'b0;
        tick(P);
        ext_drv_n = 1'b1;
        tick(2);
        chk("R6 exact width", ext, 1'b1);
        tick(1);
        chk("R6 exact width end", ext, 1'b0);
        tick(4);

        // R8, R9: set, release delay, restart during the wait
        ov[3] = 1'b1;
        tick(1);
        chk("R8", ov_n, 1'b0);
        tick(3);
        ov = '0;
        tick(REL - 1);
        chk("R9 waiting", ov_n, 1'b0);
        tick(1);
        chk("R9 released", ov_n, 1'b1);
        ov[1] = 1'b1;
        tick(1);
        ov = '0;
        tick(3);
        ov[0] = 1'b1;
        tick(1);
        chk("R8 restart", ov_n, 1'b0);
        ov = '0;
        tick(REL - 1);
        chk("R9 restart waiting", ov_n, 1'b0);
        tick(1);
        chk("R9 restart released", ov_n, 1'b1);

        // Random phase: rails, flags and state bits; own pulses only on the line
        for (int c = 0; c < 600; c++) begin
            if ($urandom % 12 == 0) good[$urandom % N] ^= 1'b1;
            if ($urandom % 40 == 0) en = ~en;
            if ($urandom % 40 == 0) shdn_n = ~shdn_n;
            if ($urandom % 6 == 0) ov = N'($urandom);
            else if ($urandom % 3 == 0) ov = '0;
            tick(1);
            chk("R7 random", ext, 1'b0);
        end

        auto_on = 1'b0;
        finish_run();
    end

endmodule